// File: doc/BRIEF.md
# Table-Driven Power Rail Sequencer

This block walks one of four built-in rail tables and drives a bus of sixteen rail enables. The tables cover four moves: bringing the standby rails up from off, raising the suspend rails from standby, dropping the suspend rails back to standby, and taking standby down to off. Each table step sets one enable to a chosen level. It then waits a chosen number of milliseconds before the next step. A step with no wait hands over to the next step on the following clock.

A higher-level power controller picks the table through a two-bit select code and fires a one-cycle start strobe. It supplies a one-cycle millisecond tick and watches busy and done. Power-good monitoring and the choice of which move to make stay with that controller. The enables keep their levels while the block is idle. A rerun of a table whose rails already sit at their target levels therefore changes nothing on the bus, but it still takes the table's full time.

Top module: `rail_seq`

## Requirements
- R1: While reset is asserted and right after it, all rail enables are 0, and busy and done are 0.
- R2: A start strobe seen while idle latches the select code: 0 = standby up from off, 1 = suspend up from standby, 2 = suspend down to standby, 3 = standby down to off. Busy is 1 from the clock edge that accepts the strobe until the sequence ends.
- R3: Bus bit positions are: 0 standby 5 V, 1 standby 1.8 V, 2 PMC I/O 1.8 V, 3 PMC 0.8 V core, 4 SoC core, 5 PMC 1.8 V/3.3 V, 6 suspend 1.8 V, 7 I/O 1.82 V, 8 suspend 3.3 V, 9 I/O 3.3 V, 10 DDR, 11 memory VDD1/VDD2, 12 memory VDDQ, 13 media, 14 GPU, 15 CPU. Steps run in table order, and at most one enable changes per clock.
- R4: After a step with a delay of N ms, the next step takes effect right after the N-th tick counted from that step.
- R5: After a step with zero delay, the next step takes effect on the next clock, with no tick counted.
- R6: Code 0 table as (bit, level, delay ms): (0,1,10) (1,1,0) (2,1,4) (3,1,0) (4,1,4) (5,1,0).
- R7: Code 1 table: (6,1,0) (7,1,4) (8,1,0) (9,1,4) (10,1,4) (11,1,4) (12,1,4) (13,1,0) (14,1,0) (15,1,0).
- R8: Code 2 table: (15,0,0) (14,0,0) (13,0,4) (12,0,4) (11,0,4) (10,0,4) (9,0,0) (8,0,4) (7,0,0) (6,0,0).
- R9: Code 3 table: (5,0,4) (4,0,0) (3,0,4) (2,0,4) (1,0,4) (0,0,4).
- R10: A start strobe that arrives while busy is ignored. The running sequence and its select code are unaffected.
- R11: Done is a one-clock pulse on the clock after the last step's delay has expired. Busy falls on the following clock.
- R12: Rail enables hold their values while idle. A step whose enable already has its target level leaves the bus unchanged but keeps its delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seq_sel_i | input | 2 | Table select code, sampled with the start strobe |
| start_i | input | 1 | One-cycle start strobe |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| rail_en_o | output | 16 | Rail enable bus |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a sequence has finished |

## Verification
The bench builds the block with its default parameters: a two-stage reset synchronizer and four-bit step delays, which covers the longest 10 ms step. It issues a tick every five clocks instead of one per real millisecond. Each full table therefore finishes in about a hundred clocks, and all four moves, a rerun on rails that are already settled and a strobe during a run fit in a short run. Ticks are lined up against the start strobe, so each tick count between bus changes can be predicted exactly.

// File: rtl/rail_seq_pkg.sv
`timescale 1ns/1ps
package rail_seq_pkg;

  localparam int NUM_RAILS = 16;
  localparam int RAIL_IW   = $clog2(NUM_RAILS);
  localparam int DLY_W     = 4;
  localparam int NUM_SEQS  = 4;
  localparam int SEL_W     = $clog2(NUM_SEQS);
  localparam int MAX_STEPS = 10;
  localparam int STEP_IW   = $clog2(MAX_STEPS);

  // Rail bit positions on the enable bus
  localparam int RL_SB5V    = 0;
  localparam int RL_SB1V8   = 1;
  localparam int RL_PMCIO   = 2;
  localparam int RL_PMCCORE = 3;
  localparam int RL_SOC     = 4;
  localparam int RL_PMCAUX  = 5;
  localparam int RL_SUS1V8  = 6;
  localparam int RL_IO1V82  = 7;
  localparam int RL_SUS3V3  = 8;
  localparam int RL_IO3V3   = 9;
  localparam int RL_DDR     = 10;
  localparam int RL_MEM12   = 11;
  localparam int RL_MEMQ    = 12;
  localparam int RL_MEDIA   = 13;
  localparam int RL_GPU     = 14;
  localparam int RL_CPU     = 15;

  typedef enum logic [SEL_W-1:0] {
    SEQ_UP_STBY = 2'd0,
    SEQ_UP_SUSP = 2'd1,
    SEQ_DN_STBY = 2'd2,
    SEQ_DN_OFF  = 2'd3
  } seq_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_APPLY,
    ST_WAIT,
    ST_FINISH
  } st_e;

  typedef struct packed {
    logic [RAIL_IW-1:0] rail;
    logic               lvl;
    logic [DLY_W-1:0]   dly;
  } step_t;

  function automatic step_t mk_step(input int r, input logic l, input int d);
    step_t s;
    s.rail = RAIL_IW'(r);
    s.lvl  = l;
    s.dly  = DLY_W'(d);
    return s;
  endfunction

  function automatic logic [STEP_IW-1:0] seq_last(input seq_e s);
    case (s)
      SEQ_UP_STBY: return STEP_IW'(5);
      SEQ_UP_SUSP: return STEP_IW'(9);
      SEQ_DN_STBY: return STEP_IW'(9);
      default:     return STEP_IW'(5);
    endcase
  endfunction

  function automatic step_t seq_step(input seq_e s, input logic [STEP_IW-1:0] i);
    step_t e;
    e = mk_step(0, 1'b0, 0);
    case (s)
      SEQ_UP_STBY: begin
        case (int'(i))
          0: e = mk_step(RL_SB5V,    1'b1, 10);
          1: e = mk_step(RL_SB1V8,   1'b1, 0);
          2: e = mk_step(RL_PMCIO,   1'b1, 4);
          3: e = mk_step(RL_PMCCORE, 1'b1, 0);
          4: e = mk_step(RL_SOC,     1'b1, 4);
          5: e = mk_step(RL_PMCAUX,  1'b1, 0);
          default: ;
        endcase
      end
      SEQ_UP_SUSP: begin
        case (int'(i))
          0: e = mk_step(RL_SUS1V8, 1'b1, 0);
          1: e = mk_step(RL_IO1V82, 1'b1, 4);
          2: e = mk_step(RL_SUS3V3, 1'b1, 0);
          3: e = mk_step(RL_IO3V3,  1'b1, 4);
          4: e = mk_step(RL_DDR,    1'b1, 4);
          5: e = mk_step(RL_MEM12,  1'b1, 4);
          6: e = mk_step(RL_MEMQ,   1'b1, 4);
          7: e = mk_step(RL_MEDIA,  1'b1, 0);
          8: e = mk_step(RL_GPU,    1'b1, 0);
          9: e = mk_step(RL_CPU,    1'b1, 0);
          default: ;
        endcase
      end
      SEQ_DN_STBY: begin
        case (int'(i))
          0: e = mk_step(RL_CPU,    1'b0, 0);
          1: e = mk_step(RL_GPU,    1'b0, 0);
          2: e = mk_step(RL_MEDIA,  1'b0, 4);
          3: e = mk_step(RL_MEMQ,   1'b0, 4);
          4: e = mk_step(RL_MEM12,  1'b0, 4);
          5: e = mk_step(RL_DDR,    1'b0, 4);
          6: e = mk_step(RL_IO3V3,  1'b0, 0);
          7: e = mk_step(RL_SUS3V3, 1'b0, 4);
          8: e = mk_step(RL_IO1V82, 1'b0, 0);
          9: e = mk_step(RL_SUS1V8, 1'b0, 0);
          default: ;
        endcase
      end
      default: begin
        case (int'(i))
          0: e = mk_step(RL_PMCAUX,  1'b0, 4);
          1: e = mk_step(RL_SOC,     1'b0, 0);
          2: e = mk_step(RL_PMCCORE, 1'b0, 4);
          3: e = mk_step(RL_PMCIO,   1'b0, 4);
          4: e = mk_step(RL_SB1V8,   1'b0, 4);
          5: e = mk_step(RL_SB5V,    1'b0, 4);
          default: ;
        endcase
      end
    endcase
    return e;
  endfunction

endpackage

// File: rtl/rail_seq_rst_sync.sv
`timescale 1ns/1ps
module rail_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sh_q <= '0;
    else          sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sh_q[STAGES-1];

endmodule

// File: rtl/rail_seq_rom.sv
`timescale 1ns/1ps
module rail_seq_rom
  import rail_seq_pkg::*;
(
  input  seq_e               sel_i,
  input  logic [STEP_IW-1:0] idx_i,
  output step_t              step_o,
  output logic               last_o
);

  always_comb begin
    step_o = seq_step(sel_i, idx_i);
    last_o = (idx_i == seq_last(sel_i));
  end

endmodule

// File: rtl/rail_seq_timer.sv
`timescale 1ns/1ps
module rail_seq_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         expire_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_val_i;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = tick_i && !load_i && (cnt_q == W'(1));

endmodule

// File: rtl/rail_seq_bank.sv
`timescale 1ns/1ps
module rail_seq_bank #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic          wr_lvl_i,
  output logic [N-1:0]  en_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic hit;
    logic q;

    assign hit = wr_en_i && (wr_idx_i == IW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= 1'b0;
      else if (hit) q <= wr_lvl_i;
    end

    assign en_o[g] = q;
  end

endmodule

// File: rtl/rail_seq.sv
`timescale 1ns/1ps
module rail_seq
  import rail_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SEL_W-1:0]     seq_sel_i,
  input  logic                 start_i,
  input  logic                 ms_tick_i,
  output logic [NUM_RAILS-1:0] rail_en_o,
  output logic                 busy_o,
  output logic                 done_o
);

  logic               rst_n;
  st_e                st_q, st_d;
  seq_e               sel_q, sel_d;
  logic               sel_en;
  logic [STEP_IW-1:0] idx_q, idx_d;
  logic               idx_en;
  step_t              cur;
  logic               last;
  logic               expire;
  logic               wr_en;
  logic               tmr_load;

  rail_seq_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n)
  );

  rail_seq_rom u_rom (
    .sel_i  (sel_q),
    .idx_i  (idx_q),
    .step_o (cur),
    .last_o (last)
  );

  rail_seq_timer #(.W(DLY_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .load_i     (tmr_load),
    .load_val_i (cur.dly),
    .tick_i     (ms_tick_i),
    .expire_o   (expire)
  );

  rail_seq_bank #(.N(NUM_RAILS), .IW(RAIL_IW)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .wr_idx_i (cur.rail),
    .wr_lvl_i (cur.lvl),
    .en_o     (rail_en_o)
  );

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    sel_d    = sel_q;
    sel_en   = 1'b0;
    idx_d    = idx_q;
    idx_en   = 1'b0;
    wr_en    = 1'b0;
    tmr_load = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          sel_d  = seq_e'(seq_sel_i);
          sel_en = 1'b1;
          idx_d  = '0;
          idx_en = 1'b1;
          st_d   = ST_APPLY;
        end
      end
      ST_APPLY: begin
        wr_en = 1'b1;
        if (cur.dly == '0) begin
          if (last) begin
            st_d = ST_FINISH;
          end else begin
            idx_d  = idx_q + STEP_IW'(1);
            idx_en = 1'b1;
          end
        end else begin
          tmr_load = 1'b1;
          st_d     = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (expire) begin
          if (last) begin
            st_d = ST_FINISH;
          end else begin
            idx_d  = idx_q + STEP_IW'(1);
            idx_en = 1'b1;
            st_d   = ST_APPLY;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sel_q <= SEQ_UP_STBY;
      idx_q <= '0;
    end else begin
      st_q <= st_d;
      if (sel_en) sel_q <= sel_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_FINISH);

endmodule

// File: rtl/rail_seq_chk.sv
`timescale 1ns/1ps
module rail_seq_chk
  import rail_seq_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic [NUM_RAILS-1:0] rail_en_o
);

  // R2
  start_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  // R3
  one_rail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($countones(rail_en_o ^ $past(rail_en_o)) <= 1));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(rail_en_o));

endmodule

bind rail_seq rail_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .rail_en_o (rail_en_o)
);

// File: tb/rail_seq_test.sv
`timescale 1ns/1ps
module rail_seq_test;

  logic        clk;
  logic        rst_n;
  logic [1:0]  sel;
  logic        start;
  logic        tick;
  logic [15:0] rail_en;
  logic        busy;
  logic        done;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;
  bit mon_on = 0;

  logic [15:0] exp_vec_q[$];
  int          exp_tck_q[$];
  bit          exp_fin_q[$];
  string       exp_tag_q[$];

  logic [15:0] model = '0;

  rail_seq uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .seq_sel_i (sel),
    .start_i   (start),
    .ms_tick_i (tick),
    .rail_en_o (rail_en),
    .busy_o    (busy),
    .done_o    (done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Tick every five clocks, driven just after a rising edge
  initial begin
    tick = 1'b0;
    forever begin
      repeat (4) @(posedge clk);
      #1 tick = 1'b1;
      @(posedge clk);
      #1 tick = 1'b0;
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  // Independent copy of the four tables (R6 R7 R8 R9)
  task automatic bstep(input int s, input int i, output int r, output int l, output int d);
    r = 0; l = 0; d = 0;
    case (s * 16 + i)
      0:  begin r = 0;  l = 1; d = 10; end
      1:  begin r = 1;  l = 1; d = 0;  end
      2:  begin r = 2;  l = 1; d = 4;  end
      3:  begin r = 3;  l = 1; d = 0;  end
      4:  begin r = 4;  l = 1; d = 4;  end
      5:  begin r = 5;  l = 1; d = 0;  end
      16: begin r = 6;  l = 1; d = 0;  end
      17: begin r = 7;  l = 1; d = 4;  end
      18: begin r = 8;  l = 1; d = 0;  end
      19: begin r = 9;  l = 1; d = 4;  end
      20: begin r = 10; l = 1; d = 4;  end
      21: begin r = 11; l = 1; d = 4;  end
      22: begin r = 12; l = 1; d = 4;  end
      23: begin r = 13; l = 1; d = 0;  end
      24: begin r = 14; l = 1; d = 0;  end
      25: begin r = 15; l = 1; d = 0;  end
      32: begin r = 15; l = 0; d = 0;  end
      33: begin r = 14; l = 0; d = 0;  end
      34: begin r = 13; l = 0; d = 4;  end
      35: begin r = 12; l = 0; d = 4;  end
      36: begin r = 11; l = 0; d = 4;  end
      37: begin r = 10; l = 0; d = 4;  end
      38: begin r = 9;  l = 0; d = 0;  end
      39: begin r = 8;  l = 0; d = 4;  end
      40: begin r = 7;  l = 0; d = 0;  end
      41: begin r = 6;  l = 0; d = 0;  end
      48: begin r = 5;  l = 0; d = 4;  end
      49: begin r = 4;  l = 0; d = 0;  end
      50: begin r = 3;  l = 0; d = 4;  end
      51: begin r = 2;  l = 0; d = 4;  end
      52: begin r = 1;  l = 0; d = 4;  end
      53: begin r = 0;  l = 0; d = 4;  end
      default: ;
    endcase
  endtask

  function automatic int blen(input int s);
    return (s == 1 || s == 2) ? 10 : 6;
  endfunction

  // Driver: push expected bus changes and the done event, then run
  task automatic run_seq(input int s, input string stag, input bit poke);
    int acc;
    acc = 0;
    for (int i = 0; i < blen(s); i++) begin
      int r, l, d;
      logic [15:0] nv;
      bstep(s, i, r, l, d);
      nv = model;
      nv[r] = l[0];
      if (nv != model) begin
        exp_vec_q.push_back(nv);
        exp_tck_q.push_back(acc);
        exp_fin_q.push_back(1'b0);
        // R3 order, R4 counted wait, R5 no wait
        exp_tag_q.push_back($sformatf("%s R3 %s", stag, (acc > 0) ? "R4" : "R5"));
        model = nv;
        acc = 0;
      end
      acc += d;
    end
    exp_vec_q.push_back(model);
    exp_tck_q.push_back(acc);
    exp_fin_q.push_back(1'b1);
    exp_tag_q.push_back($sformatf("%s R11", stag));

    @(posedge clk);
    while (!tick) @(posedge clk);
    #1 start = 1'b1; sel = 2'(s);
    @(posedge clk);
    #1 start = 1'b0;
    @(negedge clk);
    check(busy === 1'b1, "R2", $sformatf("busy after start got %b exp 1", busy));
    if (poke) begin
      repeat (6) @(posedge clk);
      #1 start = 1'b1; sel = 2'(s ^ 2);
      @(posedge clk);
      #1 start = 1'b0;
    end
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    check(rail_en === model, "R12",
          $sformatf("idle hold got %h exp %h", rail_en, model));
  endtask

  // Monitor: compare each bus change and done pulse with the queue
  initial begin
    logic [15:0] prev_en;
    bit prev_done;
    int cnt;
    prev_en = '0; prev_done = 0; cnt = 0;
    wait (mon_on);
    forever begin
      @(negedge clk);
      if (rail_en !== prev_en) begin
        if (exp_vec_q.size() == 0) begin
          check(0, "R3", $sformatf("unexpected bus %h exp none", rail_en));
        end else begin
          logic [15:0] ev; int et; bit ef; string tg;
          ev = exp_vec_q.pop_front(); et = exp_tck_q.pop_front();
          ef = exp_fin_q.pop_front(); tg = exp_tag_q.pop_front();
          check(!ef && rail_en === ev && cnt == et, tg,
                $sformatf("bus %h ticks %0d done %b exp bus %h ticks %0d done %b",
                          rail_en, cnt, 1'b0, ev, et, ef));
        end
        prev_en = rail_en;
        cnt = 0;
      end
      if (done) begin
        if (exp_vec_q.size() == 0) begin
          check(0, "R11", "unexpected done got 1 exp 0");
        end else begin
          logic [15:0] ev; int et; bit ef; string tg;
          ev = exp_vec_q.pop_front(); et = exp_tck_q.pop_front();
          ef = exp_fin_q.pop_front(); tg = exp_tag_q.pop_front();
          check(ef && rail_en === ev && cnt == et, tg,
                $sformatf("done bus %h ticks %0d exp bus %h ticks %0d fin %b",
                          rail_en, cnt, ev, et, ef));
        end
        cnt = 0;
      end
      if (prev_done)
        check(!done && !busy, "R11",
              $sformatf("after done got done %b busy %b exp 0 0", done, busy));
      prev_done = done;
      if (busy && tick) cnt++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, got timeout exp completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; sel = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rail_en === '0 && busy === 1'b0 && done === 1'b0, "R1",
          $sformatf("reset got en %h busy %b done %b exp 0 0 0", rail_en, busy, done));
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(rail_en === '0 && busy === 1'b0 && done === 1'b0, "R1",
          $sformatf("after reset got en %h busy %b done %b exp 0 0 0", rail_en, busy, done));
    mon_on = 1;
    run_seq(0, "R6", 0);
    run_seq(1, "R7", 0);
    run_seq(2, "R8 R10", 1);  // strobe while busy must be ignored
    run_seq(3, "R9", 0);
    run_seq(3, "R12", 0);     // rails already off: no change, full time
    run_seq(0, "R6", 0);
    repeat (10) @(negedge clk);
    check(exp_vec_q.size() == 0, "R11",
          $sformatf("pending events got %0d exp 0", exp_vec_q.size()));
    finish_run();
  end

endmodule